// File: doc/BRIEF.md
# Versioned release-ordering store buffer

This block holds committed stores between the pipeline and the cache and enforces release ordering without draining itself at every fence. Each store is tagged with the current ordering epoch, called its version. Accepting a store-release or a full fence closes the current version: the counter advances, and the closed version goes into a small FIFO of pending ordering points. The ordering instruction can therefore leave the reorder buffer at once, because its constraint is kept in the FIFO.

Stores that follow an ordering point enter the buffer immediately and wait there. The drain side offers the cache one store at a time over a valid/ready handshake. It only offers stores of the oldest unfinished version. Inside that version, plain stores may leave in any order, and a release store leaves last. When no entry of the oldest pending ordering point remains, that point is retired. The block outputs the newest fully completed version, so a load queue can decide whether a speculative load must be squashed.

Top module: `rel_store_buffer`

## Requirements
- R1: The version counter is 4 bits wide, resets to 0 and advances by one, modulo 16, on every accepted release store or fence. Each store is tagged with the counter value at the cycle it is accepted.
- R2: `iss_kind` is encoded as 0 for a plain store, 1 for a store-release, 2 for a full fence, and 3 is treated as a plain store. `iss_ready` is high for a fence when fewer than 4 ordering points are pending. For a plain store it is high when fewer than 8 entries are occupied. A release store needs both conditions.
- R3: `dr_valid` only ever offers an entry whose version is the oldest unfinished version. That is the head of the ordering FIFO, or the current counter value when the FIFO is empty.
- R4: A release store is offered only when it is the sole remaining entry of its version. `dr_release` is high exactly when the offered entry is a release store.
- R5: `dr_valid` is high in every cycle in which some buffered entry meets R3 and R4.
- R6: While `dr_valid` is high and `dr_ready` is low, the offered address, data and release flag stay unchanged. An entry leaves only on the cycle `dr_valid` and `dr_ready` are both high, and every accepted store is delivered exactly once.
- R7: An ordering point is retired one cycle after no entry of its version remains. `drained_version` equals the oldest unfinished version minus one, modulo 16.
- R8: Stores and ordering instructions issued after an ordering point are accepted while older stores are still buffered, subject only to R2.
- R9: After reset the buffer is empty, `dr_valid` is low, `drained_version` is 15 and `iss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request from the pipeline |
| iss_kind | input | 2 | 0 store, 1 store-release, 2 full fence, 3 store |
| iss_addr | input | 32 | Store address |
| iss_data | input | 32 | Store data |
| iss_ready | output | 1 | Request accepted this cycle when high with iss_valid |
| dr_valid | output | 1 | A store is offered to the cache |
| dr_addr | output | 32 | Offered store address |
| dr_data | output | 32 | Offered store data |
| dr_release | output | 1 | Offered store is a release |
| dr_ready | input | 1 | Cache accepts the offered store |
| drained_version | output | 4 | Newest version whose stores have all completed |

## Verification
The hardest situation to reach is a full ordering FIFO while the buffer still holds entries of several versions. In that state fences and releases must be refused, plain stores still enter, and a release must wait behind later-arriving stores of its own version. The stimulus first fills the buffer with the cache port stalled. It then issues fences until the FIFO is full and tries releases and stores against both limits. After that comes a long random mix of store kinds with random cache back-pressure, which wraps the 4-bit version several times. A behavioural model of the outstanding stores and pending ordering points checks the readiness, the legality of each offered store and the drained version on every cycle.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    K_STORE   = 2'd0,
    K_RELEASE = 2'd1,
    K_FENCE   = 2'd2
  } kind_e;
endpackage

// File: rtl/rsb_ord_fifo.sv
// FIFO of pending ordering points; each holds the version it closed.
module rsb_ord_fifo #(
  parameter int VW     = 4,
  parameter int ODEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [VW-1:0] push_ver,
  input  logic          pop,
  output logic          empty,
  output logic          full,
  output logic [VW-1:0] head_ver
);
  localparam int PW = (ODEPTH > 1) ? $clog2(ODEPTH) : 1;
  localparam int CW = $clog2(ODEPTH + 1);

  logic [VW-1:0] mem [ODEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(ODEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(ODEPTH));
  assign head_ver = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ver;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assert_push_not_full_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_pop_not_empty_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/rsb_entries.sv
// Entry storage: lowest free slot is allocated, slots freed on drain.
module rsb_entries #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int VW    = 4,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [VW-1:0]    wr_ver,
  input  logic             wr_rel,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  input  logic [IW-1:0]    rd_idx,
  output logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [DEPTH-1:0] vld,
  output logic [DEPTH-1:0] rel,
  output logic [VW-1:0]    ver [DEPTH],
  output logic             full
);
  logic [AW-1:0] a_mem [DEPTH];
  logic [DW-1:0] d_mem [DEPTH];
  logic [IW-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IW'(i);
  end

  assign full    = &vld;
  assign rd_addr = a_mem[rd_idx];
  assign rd_data = d_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      a_mem[free_idx] <= wr_addr;
      d_mem[free_idx] <= wr_data;
      ver[free_idx]   <= wr_ver;
      rel[free_idx]   <= wr_rel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else begin
      if (clr_en) vld[clr_idx]  <= 1'b0;
      if (wr_en)  vld[free_idx] <= 1'b1;
    end
  end

  assert_slot_free_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  assert_clear_live_R6: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> vld[clr_idx]);
endmodule

// File: rtl/rsb_drain_sel.sv
// Picks a drainable entry of the oldest version and holds it until accepted.
module rsb_drain_sel #(
  parameter int VW    = 4,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] rel,
  input  logic [VW-1:0]    ver [DEPTH],
  input  logic [VW-1:0]    oldest,
  input  logic             dr_ready,
  output logic             dr_valid,
  output logic [IW-1:0]    sel_idx,
  output logic [CW-1:0]    n_oldest
);
  logic [DEPTH-1:0] elig;
  logic [IW-1:0]    pick, held_idx;
  logic             hold;

  always_comb begin
    n_oldest = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && ver[i] == oldest) n_oldest += CW'(1);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      elig[i] = vld[i] && (ver[i] == oldest) && (!rel[i] || n_oldest == CW'(1));
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (elig[i]) pick = IW'(i);
  end

  assign sel_idx  = hold ? held_idx : pick;
  assign dr_valid = hold | (|elig);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= 1'b0;
      held_idx <= '0;
    end else begin
      hold     <= dr_valid && !dr_ready;
      held_idx <= sel_idx;
    end
  end

  assert_offer_held_R6: assert property (@(posedge clk) disable iff (rst)
    (dr_valid && !dr_ready) |=> (dr_valid && sel_idx == $past(sel_idx)));
  assert_oldest_only_R3: assert property (@(posedge clk) disable iff (rst)
    dr_valid |-> (vld[sel_idx] && ver[sel_idx] == oldest));
  assert_release_last_R4: assert property (@(posedge clk) disable iff (rst)
    (dr_valid && rel[sel_idx]) |-> (n_oldest == CW'(1)));
endmodule

// File: rtl/rel_store_buffer.sv
module rel_store_buffer
  import rsb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int VW     = 4,
  parameter int DEPTH  = 8,
  parameter int ODEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [1:0]    iss_kind,
  input  logic [AW-1:0] iss_addr,
  input  logic [DW-1:0] iss_data,
  output logic          iss_ready,
  output logic          dr_valid,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data,
  output logic          dr_release,
  input  logic          dr_ready,
  output logic [VW-1:0] drained_version
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [VW-1:0]    cur_ver, head_ver, oldest;
  logic             ord_empty, ord_full, ord_push, ord_pop;
  logic             buf_full, fire, is_fence, is_rel, wr_en, dr_fire;
  logic [DEPTH-1:0] e_vld, e_rel;
  logic [VW-1:0]    e_ver [DEPTH];
  logic [IW-1:0]    sel_idx;
  logic [CW-1:0]    n_oldest;

  assign is_fence  = (iss_kind == K_FENCE);
  assign is_rel    = (iss_kind == K_RELEASE);
  assign iss_ready = is_fence ? !ord_full : (!buf_full && (!is_rel || !ord_full));
  assign fire      = iss_valid && iss_ready;
  assign wr_en     = fire && !is_fence;
  assign ord_push  = fire && (is_fence || is_rel);
  assign oldest    = ord_empty ? cur_ver : head_ver;
  assign ord_pop   = !ord_empty && (n_oldest == '0);
  assign dr_fire   = dr_valid && dr_ready;
  assign drained_version = oldest - 1'b1;
  assign dr_release = e_rel[sel_idx];

  always_ff @(posedge clk) begin
    if (rst) cur_ver <= '0;
    else if (ord_push) cur_ver <= cur_ver + 1'b1;
  end

  rsb_ord_fifo #(.VW(VW), .ODEPTH(ODEPTH)) u_ord (
    .clk(clk), .rst(rst), .push(ord_push), .push_ver(cur_ver), .pop(ord_pop),
    .empty(ord_empty), .full(ord_full), .head_ver(head_ver)
  );

  rsb_entries #(.AW(AW), .DW(DW), .VW(VW), .DEPTH(DEPTH)) u_ent (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(iss_addr), .wr_data(iss_data),
    .wr_ver(cur_ver), .wr_rel(is_rel), .clr_en(dr_fire), .clr_idx(sel_idx),
    .rd_idx(sel_idx), .rd_addr(dr_addr), .rd_data(dr_data),
    .vld(e_vld), .rel(e_rel), .ver(e_ver), .full(buf_full)
  );

  rsb_drain_sel #(.VW(VW), .DEPTH(DEPTH)) u_sel (
    .clk(clk), .rst(rst), .vld(e_vld), .rel(e_rel), .ver(e_ver), .oldest(oldest),
    .dr_ready(dr_ready), .dr_valid(dr_valid), .sel_idx(sel_idx), .n_oldest(n_oldest)
  );

  // drained_version moves only when an ordering point retires or is created
  assert_drained_steady_R7: assert property (@(posedge clk) disable iff (rst)
    (!ord_pop && !ord_push) |=> $stable(drained_version));
endmodule

// File: tb/tb_rel_store_buffer.sv
module tb_rel_store_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_kind = 2'd0;
  logic [31:0] iss_addr = '0, iss_data = '0;
  logic        iss_ready, dr_valid, dr_release;
  logic [31:0] dr_addr, dr_data;
  logic        dr_ready = 1'b0;
  logic [3:0]  drained_version;

  always #5 clk = ~clk;

  rel_store_buffer dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_addr(iss_addr), .iss_data(iss_data), .iss_ready(iss_ready),
    .dr_valid(dr_valid), .dr_addr(dr_addr), .dr_data(dr_data),
    .dr_release(dr_release), .dr_ready(dr_ready), .drained_version(drained_version)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; int v; bit r; } ent_t;
  ent_t mq[$];
  int   oq[$];
  int   mver = 0;
  int   checks = 0, errors = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int count_ver(input int v);
    int n = 0;
    foreach (mq[i]) if (mq[i].v == v) n++;
    return n;
  endfunction

  initial begin
    bit          prev_hold = 0;
    logic [31:0] prev_d = '0, prev_a = '0;
    int          seq = 1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(dr_valid == 1'b0, "R9", "reset dr_valid", dr_valid, 0);
    chk(drained_version == 4'd15, "R9", "reset drained_version", drained_version, 15);
    chk(iss_ready == 1'b1, "R9", "reset iss_ready", iss_ready, 1);

    for (int cyc = 0; cyc < 4200; cyc++) begin
      int  oldest, exp_dv, n_old, hit;
      bit  exp_rdy, any_elig, f_iss, f_dr, pop;
      @(negedge clk);
      if (cyc < 20) begin
        iss_valid = 1; iss_kind = 2'd0; dr_ready = 0;
      end else if (cyc < 30) begin
        iss_valid = 1; iss_kind = 2'd2; dr_ready = 0;
      end else if (cyc < 35) begin
        iss_valid = 1; iss_kind = 2'd1; dr_ready = 0;
      end else if (cyc < 40) begin
        iss_valid = 1; iss_kind = 2'd3; dr_ready = 0;
      end else if (cyc < 4000) begin
        int r = $urandom % 10;
        iss_valid = ($urandom % 4) != 0;
        iss_kind  = (r < 5) ? 2'd0 : (r < 6) ? 2'd3 : (r < 8) ? 2'd1 : 2'd2;
        dr_ready  = ((cyc / 150) % 3 == 1) ? (($urandom % 10) < 2) : (($urandom % 10) < 7);
      end else begin
        iss_valid = 0; iss_kind = 2'd0; dr_ready = 1;
      end
      iss_addr = $urandom;
      iss_data = seq;
      seq++;
      #1;
      oldest = (oq.size() > 0) ? oq[0] : mver;
      exp_dv = (oldest + 15) % 16;
      chk(drained_version == exp_dv[3:0], "R7", "drained_version", drained_version, exp_dv);
      if (iss_kind == 2'd2) exp_rdy = oq.size() < 4;
      else exp_rdy = (mq.size() < 8) && (iss_kind != 2'd1 || oq.size() < 4);
      chk(iss_ready == exp_rdy, "R2 R8", "iss_ready", iss_ready, exp_rdy);
      n_old = count_ver(oldest);
      any_elig = 0;
      foreach (mq[i]) if (mq[i].v == oldest && (!mq[i].r || n_old == 1)) any_elig = 1;
      chk(dr_valid == any_elig, "R5", "dr_valid", dr_valid, any_elig);
      hit = -1;
      if (dr_valid) begin
        foreach (mq[i]) if (mq[i].d == dr_data) hit = i;
        chk(hit >= 0, "R6", "offered store unknown or repeated", dr_data, 0);
        if (hit >= 0) begin
          chk(mq[hit].v == oldest, "R3 R1", "offered version", mq[hit].v, oldest);
          chk(mq[hit].a == dr_addr, "R6", "offered address", dr_addr, mq[hit].a);
          chk(dr_release == mq[hit].r, "R4", "dr_release", dr_release, mq[hit].r);
          if (mq[hit].r)
            chk(n_old == 1, "R4", "release not last of version", n_old, 1);
        end
        if (prev_hold) begin
          chk(dr_data == prev_d, "R6", "held data", dr_data, prev_d);
          chk(dr_addr == prev_a, "R6", "held address", dr_addr, prev_a);
        end
      end else if (prev_hold) begin
        chk(0, "R6", "offer withdrawn", 0, 1);
      end
      f_iss = iss_valid && exp_rdy;
      f_dr  = dr_valid && dr_ready && hit >= 0;
      prev_hold = dr_valid && !dr_ready;
      prev_d = dr_data;
      prev_a = dr_addr;
      pop = (oq.size() > 0) && (count_ver(oq[0]) == 0);
      @(posedge clk);
      if (f_dr) mq.delete(hit);
      if (pop) void'(oq.pop_front());
      if (f_iss) begin
        if (iss_kind != 2'd2) begin
          ent_t e;
          e.a = iss_addr; e.d = iss_data; e.v = mver; e.r = (iss_kind == 2'd1);
          mq.push_back(e);
        end
        if (iss_kind == 2'd1 || iss_kind == 2'd2) begin
          oq.push_back(mver);
          mver = (mver + 1) % 16;
        end
      end
    end
    @(negedge clk);
    #1;
    chk(mq.size() == 0 && dr_valid == 1'b0, "R6", "buffer not emptied", mq.size(), 0);
    chk(drained_version == 4'((mver + 15) % 16), "R1 R7", "final drained_version",
        drained_version, (mver + 15) % 16);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule